// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a two-wire bus slave that sits in front of a 128-byte memory array. It samples the bus clock and data line with the system clock, finds START and STOP conditions in the sampled stream, and checks its 7-bit device address. A write sets the internal address counter from a byte address and then collects up to 16 data bytes into a page buffer. The buffer is copied into the array when the master sends STOP.

Reads come in three forms. A read of the current address sends the byte that the counter points to. A random read is a write that carries only a byte address, followed by a repeated START and a read. A sequential read keeps streaming bytes for as long as the master acknowledges them. A single counter serves all read forms and wraps from 127 to 0.

A protect input turns the array read-only. After a committed write, a fixed busy window stands in for the nonvolatile programming time. The data line is open-drain: the block only pulls it low, through an output enable.

Top module: `twi_eeprom`

## Requirements
- R1: After reset the data line is released (`sda_oe` = 0) and the block waits for a START.
- R2: A first byte whose upper 7 bits equal 1010000 (bit 0 = R/W, 1 for read) is acknowledged. Any other value is not acknowledged, and the block then ignores every byte until the next START.
- R3: In a write, the byte after the device address sets the counter (its bit 7 is ignored). Each following data byte is acknowledged. The bytes reach the array only when STOP arrives, and they can be read back once the busy window has ended.
- R4: During a write, only the low 4 bits of the counter advance, so data rolls over inside its aligned 16-byte page. After the write the counter holds the page base plus (start offset + byte count) mod 16.
- R5: A random read (write phase carrying only a byte address, then repeated START and the address with R/W = 1) returns the byte at that address first.
- R6: A read that starts with no byte address returns the byte at the counter, which is one past the last byte read, or the value left by R4 after a write.
- R7: Each master acknowledge after a read byte makes the block send the next byte. The address wraps from 127 to 0.
- R8: When the master does not acknowledge a read byte, the block releases the data line, and it stays released through the STOP that follows.
- R9: While the protect input is high at STOP, address and data bytes are still acknowledged, but the array is unchanged and no busy window starts.
- R10: After STOP ends a write that carried data with protect low, the device address is not acknowledged for BUSY_CYC clock cycles. After that it is acknowledged again.
- R11: The block changes `sda_oe` only while the bus clock is low. A falling data line while the clock is high is a START, and a rising one is a STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than the bus clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| sda_oe | output | 1 | Pulls the data line low when 1 |
| wp_i | input | 1 | Write protect, active high |

## Verification
The busy countdown and the decoding of the device address can fall in the same stretch of cycles. This happens when the master polls straight after a committed STOP, while the array copy and the busy window are still running. The bench polls until it gets an acknowledge. It judges the result by requiring a NACK on the first poll and an ACK within a bounded number of polls, and then by reading the committed bytes back. Write protect meets the STOP handling in the same cycle as a pending page: the bench checks that a protected write still acknowledges every byte, that the very next poll is acknowledged, and that a read-back shows the old data.

// File: rtl/twi_pkg.sv
package twi_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RXD,
    ST_ACK,
    ST_TX,
    ST_TXA,
    ST_TXN
  } twi_state_e;

  typedef enum logic [1:0] {
    RL_DEV,
    RL_ADDR,
    RL_DATA
  } twi_role_e;

endpackage

// File: rtl/twi_bus_cond.sv
module twi_bus_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_pipe;
  logic [SYNC_STAGES-1:0] sda_pipe;
  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[SYNC_STAGES-1];
      sda_q    <= sda_pipe[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[SYNC_STAGES-1];
  assign sda_s     = sda_pipe[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/twi_page_buf.sv
module twi_page_buf #(
  parameter int DW = 8,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ridx,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic          any_valid
);
  localparam int SLOTS = 2 ** IW;

  logic [DW-1:0]    slot_q [SLOTS];
  logic [SLOTS-1:0] valid_q;

  always_ff @(posedge clk) begin
    if (we) slot_q[widx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      valid_q <= '0;
    end else if (we) begin
      valid_q[widx] <= 1'b1;
    end
  end

  assign rdata     = slot_q[ridx];
  assign rvalid    = valid_q[ridx];
  assign any_valid = |valid_q;

endmodule

// File: rtl/twi_array.sv
module twi_array #(
  parameter int DW = 8,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/twi_eeprom.sv
module twi_eeprom #(
  parameter logic [6:0] DEV_ADDR    = 7'b1010000,
  parameter int         AW          = 7,
  parameter int         PAGE_AW     = 4,
  parameter int         BUSY_CYC    = 400,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe,
  input  logic wp_i
);
  import twi_pkg::*;

  localparam int DW    = 8;
  localparam int BCW   = $clog2(BUSY_CYC + 1);
  localparam int PGW   = AW - PAGE_AW;
  localparam int SLOTS = 2 ** PAGE_AW;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  twi_state_e    state;
  twi_role_e     role;
  logic [2:0]    bitcnt;
  logic [DW-1:0] rxsh;
  logic [DW-1:0] txsh;
  logic          rw;
  logic [AW-1:0] ctr;

  logic               commit_on;
  logic [PAGE_AW-1:0] slot;
  logic [PGW-1:0]     cpage;
  logic [BCW-1:0]     busy_cnt;
  logic               busy;
  logic               commit_done;

  logic          pb_we, pb_clr, pb_rvalid, pb_any;
  logic [DW-1:0] pb_rdata;
  logic [DW-1:0] rd_q;
  logic          dev_acking;

  twi_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign busy        = (busy_cnt != '0);
  assign commit_done = commit_on && (slot == PAGE_AW'(SLOTS - 1));
  assign pb_we       = (state == ST_RXD) && scl_fall && (role == RL_DATA) && !start_det && !stop_det;
  assign pb_clr      = (start_det && !commit_on) || (stop_det && wp_i) || commit_done;
  assign dev_acking  = (state == ST_ACK) && (role == RL_DEV);

  twi_page_buf #(.DW(DW), .IW(PAGE_AW)) u_pbuf (
    .clk(clk), .rst(rst), .clr(pb_clr),
    .we(pb_we), .widx(ctr[PAGE_AW-1:0]), .wdata(rxsh),
    .ridx(slot), .rdata(pb_rdata), .rvalid(pb_rvalid), .any_valid(pb_any)
  );

  twi_array #(.DW(DW), .AW(AW)) u_mem (
    .clk(clk), .we(commit_on && pb_rvalid), .waddr({cpage, slot}),
    .wdata(pb_rdata), .raddr(ctr), .rdata(rd_q)
  );

  // Protocol engine
  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      role   <= RL_DEV;
      bitcnt <= '0;
      rxsh   <= '0;
      txsh   <= '0;
      rw     <= 1'b0;
      ctr    <= '0;
      sda_oe <= 1'b0;
    end else if (start_det) begin
      state  <= ST_RX;
      role   <= RL_DEV;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_RX: begin
          if (scl_rise) begin
            rxsh   <= {rxsh[DW-2:0], sda_s};
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) state <= ST_RXD;
          end
        end
        ST_RXD: begin
          if (scl_fall) begin
            unique case (role)
              RL_DEV: begin
                if ((rxsh[DW-1:1] == DEV_ADDR) && !busy) begin
                  sda_oe <= 1'b1;
                  rw     <= rxsh[0];
                  state  <= ST_ACK;
                end else begin
                  state  <= ST_IDLE;
                end
              end
              RL_ADDR: begin
                sda_oe <= 1'b1;
                ctr    <= rxsh[AW-1:0];
                state  <= ST_ACK;
              end
              default: begin
                sda_oe <= 1'b1;
                ctr[PAGE_AW-1:0] <= ctr[PAGE_AW-1:0] + 1'b1;
                state  <= ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (role == RL_DEV && rw) begin
              txsh   <= {rd_q[DW-2:0], 1'b0};
              sda_oe <= ~rd_q[DW-1];
              ctr    <= ctr + 1'b1;
              state  <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_RX;
              role   <= (role == RL_DEV) ? RL_ADDR : RL_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitcnt == 3'd7) begin
              sda_oe <= 1'b0;
              state  <= ST_TXA;
            end else begin
              sda_oe <= ~txsh[DW-1];
              txsh   <= {txsh[DW-2:0], 1'b0};
              bitcnt <= bitcnt + 3'd1;
            end
          end
        end
        ST_TXA: begin
          if (scl_rise) state <= sda_s ? ST_IDLE : ST_TXN;
        end
        ST_TXN: begin
          if (scl_fall) begin
            bitcnt <= '0;
            txsh   <= {rd_q[DW-2:0], 1'b0};
            sda_oe <= ~rd_q[DW-1];
            ctr    <= ctr + 1'b1;
            state  <= ST_TX;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Page commit and busy window
  always_ff @(posedge clk) begin
    if (rst) begin
      commit_on <= 1'b0;
      slot      <= '0;
      cpage     <= '0;
      busy_cnt  <= '0;
    end else if (stop_det && pb_any && !wp_i && !commit_on) begin
      commit_on <= 1'b1;
      slot      <= '0;
      cpage     <= ctr[AW-1:PAGE_AW];
      busy_cnt  <= BCW'(BUSY_CYC);
    end else begin
      if (busy) busy_cnt <= busy_cnt - 1'b1;
      if (commit_on) begin
        slot <= slot + 1'b1;
        if (commit_done) commit_on <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/twi_chk.sv
module twi_chk (
  input logic clk,
  input logic rst,
  input logic scl_i,
  input logic sda_oe,
  input logic wp_i,
  input logic stop_det,
  input logic commit_on,
  input logic busy,
  input logic dev_acking
);

  // R1
  released_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !sda_oe);

  // R11
  sda_moves_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> !scl_i);

  // R9
  protect_blocks_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_det && wp_i) |=> !$rose(commit_on));

  // R10
  no_ack_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dev_acking) |-> !busy);

  // R10
  commit_inside_busy_chk: assert property (@(posedge clk) disable iff (rst)
    commit_on |-> busy);

endmodule

bind twi_eeprom twi_chk u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe), .wp_i(wp_i),
  .stop_det(stop_det), .commit_on(commit_on), .busy(busy), .dev_acking(dev_acking)
);

// File: tb/sim_twi_eeprom.sv
`timescale 1ns/1ps
module sim_twi_eeprom;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic msda = 1'b1;
  logic wp = 1'b0;
  logic sda_oe;
  logic sda_line;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [7:0] model [128];
  int mctr = 0;

  always #2 clk = ~clk;
  assign sda_line = msda & ~sda_oe;

  twi_eeprom u0 (.clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe), .wp_i(wp));

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic i2c_start();
    hw(H/2); msda = 1'b1; hw(H/2); scl = 1'b1; hw(H); msda = 1'b0; hw(H); scl = 1'b0;
  endtask

  task automatic i2c_stop();
    hw(H/2); msda = 1'b0; hw(H/2); scl = 1'b1; hw(H); msda = 1'b1; hw(H);
  endtask

  task automatic put_bit(input bit b);
    hw(H/2); msda = b; hw(H/2); scl = 1'b1; hw(H); scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    hw(H/2); msda = 1'b1; hw(H/2); scl = 1'b1; hw(H/2);
    ack = ~sda_line;
    hw(H/2); scl = 1'b0;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      hw(H/2); msda = 1'b1; hw(H/2); scl = 1'b1; hw(H/2);
      d[i] = sda_line;
      hw(H/2); scl = 1'b0;
    end
    put_bit(~mack);
  endtask

  task automatic poll(output int tries);
    bit ack;
    tries = 0;
    do begin
      i2c_start(); send_byte(8'hA0, ack); i2c_stop();
      tries++;
    end while (!ack && tries < 40);
  endtask

  task automatic do_write(input logic [6:0] addr, input int n, input logic [7:0] seed, input string req);
    bit ack;
    logic [6:0] a;
    i2c_start();
    send_byte(8'hA0, ack); check(ack, {req, " device ack"}, ack, 1);
    send_byte({1'b0, addr}, ack); check(ack, {req, " address ack"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      logic [7:0] v;
      v = seed + 8'(k * 7);
      send_byte(v, ack); check(ack, {req, " data ack"}, ack, 1);
      a = {addr[6:4], 4'(addr[3:0] + k)};
      if (!wp) model[a] = v;
    end
    i2c_stop();
    mctr = {addr[6:4], 4'(addr[3:0] + n)};
  endtask

  task automatic read_bytes(input int n, input string req);
    logic [7:0] d;
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, d);
      check(d === model[mctr], req, d, model[mctr]);
      mctr = (mctr + 1) % 128;
    end
    i2c_stop();
    hw(2);
    check(sda_oe == 1'b0, "R8 released after master NACK and STOP", sda_oe, 0);
  endtask

  task automatic rand_read(input logic [6:0] addr, input int n, input string req);
    bit ack;
    i2c_start();
    send_byte(8'hA0, ack); check(ack, {req, " dummy write device ack"}, ack, 1);
    send_byte({1'b0, addr}, ack); check(ack, {req, " dummy address ack"}, ack, 1);
    i2c_start();
    send_byte(8'hA1, ack); check(ack, {req, " read device ack"}, ack, 1);
    mctr = addr;
    read_bytes(n, req);
  endtask

  task automatic cur_read(input int n, input string req);
    bit ack;
    i2c_start();
    send_byte(8'hA1, ack); check(ack, {req, " read device ack"}, ack, 1);
    read_bytes(n, req);
  endtask

  task automatic t_reset();
    check(sda_oe == 1'b0, "R1 sda released after reset", sda_oe, 0);
  endtask

  task automatic t_wrong_addr();
    bit ack;
    i2c_start();
    send_byte(8'hA2, ack); check(!ack, "R2 foreign address NACKed", ack, 0);
    send_byte(8'hA0, ack); check(!ack, "R2 idle until next START", ack, 0);
    i2c_stop();
    check(sda_oe == 1'b0, "R11 line free after STOP", sda_oe, 0);
  endtask

  task automatic t_fill();
    int tries;
    do_write(7'h10, 16, 8'h40, "R3 page write");
    poll(tries);
    check(tries > 1, "R10 first poll NACKed while busy", tries, 2);
    check(tries < 40, "R10 ACK after busy window", tries, 39);
    do_write(7'h70, 16, 8'h80, "R3 page write");
    poll(tries);
    do_write(7'h00, 16, 8'hC0, "R3 page write");
    poll(tries);
    rand_read(7'h10, 16, "R3 page read back");
  endtask

  task automatic t_single();
    int tries;
    do_write(7'h03, 1, 8'h5A, "R3 byte write");
    poll(tries);
    check(tries > 1 && tries < 40, "R10 busy after byte write", tries, 2);
    rand_read(7'h03, 1, "R5 random read of byte write");
  endtask

  task automatic t_rollover();
    int tries;
    do_write(7'h1C, 6, 8'h01, "R4 rolling write");
    poll(tries);
    check(mctr == 7'h12, "R4 counter model", mctr, 7'h12);
    cur_read(1, "R6 R4 current read after rollover");
    rand_read(7'h10, 6, "R4 rolled bytes");
    rand_read(7'h1C, 4, "R4 page tail");
  endtask

  task automatic t_seq_wrap();
    rand_read(7'h7E, 4, "R7 sequential wrap 127 to 0");
    cur_read(2, "R6 current address after sequential read");
  endtask

  task automatic t_protect();
    int tries;
    wp = 1'b1;
    do_write(7'h03, 2, 8'hEE, "R9 protected write acks");
    poll(tries);
    check(tries == 1, "R9 no busy window under protect", tries, 1);
    wp = 1'b0;
    rand_read(7'h03, 2, "R9 array unchanged");
  endtask

  initial begin
    hw(150000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    hw(5);
    rst = 1'b0;
    hw(3);
    t_reset();
    t_wrong_addr();
    t_fill();
    t_single();
    t_rollover();
    t_seq_wrap();
    t_protect();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule